// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for an active-matrix LCD panel: a horizontal sync, a vertical sync, a data-enable (AC-bias) strobe, a field identifier, and the current pixel and line positions. The pixel counter moves one step for every cycle in which the pixel-clock enable is high, so the block runs on the system clock and a separate divider sets the pixel rate. Each axis is described by four values, all stored as value minus one: the active size, the front porch, the sync width and the back porch. Within a period the order is active, then front porch, then sync, then back porch.

Timing values are copied into shadow registers while the output is disabled and at each frame (or field) boundary. A timing change made in the middle of a frame therefore takes effect on the next frame, and no partial frame is produced. Each of the sync and data-enable outputs can be inverted, and either sync can be gated to its inactive level. The block supports progressive and interlaced scan. The scan mode and the first field are taken only while the output is disabled. A flag reports when the horizontal blanking, scaled by the pixel clock divisor, is too short.

Top module: `lcd_sync_gen`

## Requirements
- R1: While in reset all outputs are 0. While `out_en` is low, both counters are held at 0, and one clock later `hsync_o`, `vsync_o` and `de_o` show their inactive levels (0, or 1 where inverted).
- R2: With the output enabled, `pix_cnt` counts 0 up to Htotal-1 and then wraps, where Htotal = (h_act_m1+1)+(h_fp_m1+1)+(h_sw_m1+1)+(h_bp_m1+1). HSYNC is active while the pixel position lies in [Hact+Hfp, Hact+Hfp+Hsw).
- R3: `line_cnt` advances by one at every horizontal wrap and wraps after the last line of the field. VSYNC is active on the lines [Vact+Vfp, Vact+Vfp+Vsw), using the same active, front, sync, back order.
- R4: Before inversion, DE is active only when the pixel position is below Hact and the line is below the active line count.
- R5: `inv_hsync`, `inv_vsync` and `inv_de` each invert only their own output. Inverted means active-low; not inverted means active-high.
- R6: While `gate_hsync` (or `gate_vsync`) is high, that sync output is held at its inactive level one clock later.
- R7: After reset the block is in progressive mode, and in progressive mode `fid_o` is 0.
- R8: In interlaced mode each field has floor((v_act_m1+1)/2) active lines plus the programmed vertical blanking. FID starts at `fid_first_req` when the output is enabled and toggles at the end of each field.
- R9: `ilace_req` and `fid_first_req` are taken only while `out_en` is low. Changes made while enabled have no effect on the scan.
- R10: Timing fields are loaded into the shadow registers only while disabled or on the step that ends a frame or field. A change made mid-frame first affects the next frame.
- R11: `blank_err` is 1 exactly when ((h_fp_m1+1)+(h_sw_m1+1)+(h_bp_m1+1)) × `clk_div` is not greater than 8, using the current inputs. It is registered with one clock of latency.
- R12: All outputs are registered and reflect the counter state one clock earlier. The counters hold their value in any cycle where `pix_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable, one pixel per high cycle |
| out_en | input | 1 | Output enable; low keeps the raster idle |
| h_act_m1 | input | FLD_W | Active width minus one |
| h_fp_m1 | input | FLD_W | Horizontal front porch minus one |
| h_sw_m1 | input | FLD_W | Horizontal sync width minus one |
| h_bp_m1 | input | FLD_W | Horizontal back porch minus one |
| v_act_m1 | input | FLD_W | Active height minus one |
| v_fp_m1 | input | FLD_W | Vertical front porch minus one |
| v_sw_m1 | input | FLD_W | Vertical sync width minus one |
| v_bp_m1 | input | FLD_W | Vertical back porch minus one |
| clk_div | input | DIV_W | Pixel clock divisor used for the blanking check |
| inv_hsync | input | 1 | Invert HSYNC |
| inv_vsync | input | 1 | Invert VSYNC |
| inv_de | input | 1 | Invert DE |
| gate_hsync | input | 1 | Hold HSYNC inactive |
| gate_vsync | input | 1 | Hold VSYNC inactive |
| ilace_req | input | 1 | 1 selects interlaced scan (taken while disabled) |
| fid_first_req | input | 1 | FID value of the first field (taken while disabled) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| fid_o | output | 1 | Field identifier |
| pix_cnt | output | CNT_W | Current pixel position |
| line_cnt | output | CNT_W | Current line position |
| blank_err | output | 1 | Horizontal blanking too short |

## Verification
A reference raster model runs with an unbroken pixel enable and also with an enable that drops one cycle in three. Comparing the two separates counting on the system clock from counting on pixel steps. Separate runs with the inversion bits set and with each gate set show which control reaches which output. A mid-frame change of the timing fields shows whether the update waits for the frame boundary. An interlaced run with an odd active height checks the rounded-down field length and the FID sequence, and mode changes made while enabled must leave that run unchanged. Blanking-sum and divisor pairs placed on both sides of the limit of 8 pin down the error flag.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  parameter int unsigned FLD_W = 12;
  localparam int unsigned CNT_W = FLD_W + 3;

  typedef struct packed {
    logic [FLD_W-1:0] active;
    logic [FLD_W-1:0] front;
    logic [FLD_W-1:0] sync;
    logic [FLD_W-1:0] back;
  } axis_cfg_t;

  // stored value minus one -> length
  function automatic logic [CNT_W-1:0] span(input logic [FLD_W-1:0] f);
    return CNT_W'(f) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int unsigned CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_fp,
  input  logic [CW-1:0] len_sw,
  input  logic [CW-1:0] len_bp,
  output logic [CW-1:0] cnt_q,
  output logic          last,
  output logic          in_act,
  output logic          in_sync
);
  logic [CW-1:0] end_fp, end_sw, total;

  always_comb begin
    end_fp = len_act + len_fp;
    end_sw = end_fp + len_sw;
    total  = end_sw + len_bp;
  end

  assign last    = (cnt_q == total - CW'(1));
  assign in_act  = (cnt_q < len_act);
  assign in_sync = (cnt_q >= end_fp) && (cnt_q < end_sw);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= last ? '0 : cnt_q + CW'(1);
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(cnt_q));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear && step && last) |=> (cnt_q == '0));
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < total);
endmodule

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      out_en,
  input  logic      reload,
  input  axis_cfg_t h_live,
  input  axis_cfg_t v_live,
  input  logic      ilace_req,
  output axis_cfg_t h_sh,
  output axis_cfg_t v_sh,
  output logic      ilace_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      h_sh <= '0;
      v_sh <= '0;
    end else if (!out_en || reload) begin
      h_sh <= h_live;
      v_sh <= v_live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ilace_q <= 1'b0;
    else if (!out_en) ilace_q <= ilace_req;
  end

  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_en && !reload) |=> ($stable(h_sh) && $stable(v_sh)));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_en |=> $stable(ilace_q));
endmodule

// File: rtl/lcd_sync_out.sv
module lcd_sync_out #(
  parameter int unsigned CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          h_sync,
  input  logic          v_sync,
  input  logic          de_raw,
  input  logic          fid_raw,
  input  logic          inv_h,
  input  logic          inv_v,
  input  logic          inv_de,
  input  logic          gate_h,
  input  logic          gate_v,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          fid_o,
  output logic [CW-1:0] pix_cnt,
  output logic [CW-1:0] line_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      de_o     <= 1'b0;
      fid_o    <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      hsync_o  <= (en && h_sync && !gate_h) ^ inv_h;
      vsync_o  <= (en && v_sync && !gate_v) ^ inv_v;
      de_o     <= (en && de_raw) ^ inv_de;
      fid_o    <= fid_raw;
      pix_cnt  <= hcnt;
      line_cnt <= vcnt;
    end
  end

  p_gate_h_r6: assert property (@(posedge clk) disable iff (rst)
    gate_h |=> (hsync_o == $past(inv_h)));
  p_gate_v_r6: assert property (@(posedge clk) disable iff (rst)
    gate_v |=> (vsync_o == $past(inv_v)));
  p_idle_de_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (de_o == $past(inv_de)));
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned BLANK_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             out_en,
  input  logic [FLD_W-1:0] h_act_m1,
  input  logic [FLD_W-1:0] h_fp_m1,
  input  logic [FLD_W-1:0] h_sw_m1,
  input  logic [FLD_W-1:0] h_bp_m1,
  input  logic [FLD_W-1:0] v_act_m1,
  input  logic [FLD_W-1:0] v_fp_m1,
  input  logic [FLD_W-1:0] v_sw_m1,
  input  logic [FLD_W-1:0] v_bp_m1,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             inv_hsync,
  input  logic             inv_vsync,
  input  logic             inv_de,
  input  logic             gate_hsync,
  input  logic             gate_vsync,
  input  logic             ilace_req,
  input  logic             fid_first_req,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             fid_o,
  output logic [CNT_W-1:0] pix_cnt,
  output logic [CNT_W-1:0] line_cnt,
  output logic             blank_err
);
  localparam int unsigned PRD_W = CNT_W + DIV_W;

  axis_cfg_t h_live, v_live, h_sh, v_sh;
  logic ilace_q, fid_q;
  logic h_step, v_step, frame_end;
  logic h_last, v_last, h_act, v_act, h_syn, v_syn;
  logic [CNT_W-1:0] hcnt, vcnt, v_full, v_act_len;
  logic [CNT_W-1:0] blank_sum;
  logic [PRD_W-1:0] blank_prod;

  assign h_live = '{active: h_act_m1, front: h_fp_m1, sync: h_sw_m1, back: h_bp_m1};
  assign v_live = '{active: v_act_m1, front: v_fp_m1, sync: v_sw_m1, back: v_bp_m1};

  assign h_step    = out_en && pix_en;
  assign v_step    = h_step && h_last;
  assign frame_end = v_step && v_last;

  lcd_cfg_shadow u_shadow (
    .clk(clk), .rst(rst), .out_en(out_en), .reload(frame_end),
    .h_live(h_live), .v_live(v_live), .ilace_req(ilace_req),
    .h_sh(h_sh), .v_sh(v_sh), .ilace_q(ilace_q)
  );

  // interlaced fields carry half of the active lines, rounded down
  assign v_full    = span(v_sh.active);
  assign v_act_len = ilace_q ? (v_full >> 1) : v_full;

  lcd_axis_counter #(.CW(CNT_W)) u_hcnt (
    .clk(clk), .rst(rst), .clear(!out_en), .step(h_step),
    .len_act(span(h_sh.active)), .len_fp(span(h_sh.front)),
    .len_sw(span(h_sh.sync)), .len_bp(span(h_sh.back)),
    .cnt_q(hcnt), .last(h_last), .in_act(h_act), .in_sync(h_syn)
  );

  lcd_axis_counter #(.CW(CNT_W)) u_vcnt (
    .clk(clk), .rst(rst), .clear(!out_en), .step(v_step),
    .len_act(v_act_len), .len_fp(span(v_sh.front)),
    .len_sw(span(v_sh.sync)), .len_bp(span(v_sh.back)),
    .cnt_q(vcnt), .last(v_last), .in_act(v_act), .in_sync(v_syn)
  );

  always_ff @(posedge clk) begin
    if (rst)                       fid_q <= 1'b0;
    else if (!out_en)              fid_q <= fid_first_req;
    else if (frame_end && ilace_q) fid_q <= !fid_q;
  end

  lcd_sync_out #(.CW(CNT_W)) u_out (
    .clk(clk), .rst(rst), .en(out_en),
    .h_sync(h_syn), .v_sync(v_syn), .de_raw(h_act && v_act),
    .fid_raw(ilace_q && fid_q),
    .inv_h(inv_hsync), .inv_v(inv_vsync), .inv_de(inv_de),
    .gate_h(gate_hsync), .gate_v(gate_vsync),
    .hcnt(hcnt), .vcnt(vcnt),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .fid_o(fid_o),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  assign blank_sum  = span(h_fp_m1) + span(h_sw_m1) + span(h_bp_m1);
  assign blank_prod = PRD_W'(blank_sum) * PRD_W'(clk_div);

  always_ff @(posedge clk) begin
    if (rst) blank_err <= 1'b0;
    else     blank_err <= (blank_prod <= PRD_W'(BLANK_MIN));
  end

  p_fid_low_prog_r7: assert property (@(posedge clk) disable iff (rst)
    !ilace_q |=> !fid_o);
  p_fid_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (out_en && ilace_q && frame_end) |=> (fid_q != $past(fid_q)));
endmodule

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
  import lcd_sync_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, pix_en, out_en;
  logic [FLD_W-1:0] h_act_m1, h_fp_m1, h_sw_m1, h_bp_m1;
  logic [FLD_W-1:0] v_act_m1, v_fp_m1, v_sw_m1, v_bp_m1;
  logic [7:0] clk_div;
  logic inv_hsync, inv_vsync, inv_de, gate_hsync, gate_vsync, ilace_req, fid_first_req;
  logic hsync_o, vsync_o, de_o, fid_o, blank_err;
  logic [CNT_W-1:0] pix_cnt, line_cnt;

  lcd_sync_gen dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .out_en(out_en),
    .h_act_m1(h_act_m1), .h_fp_m1(h_fp_m1), .h_sw_m1(h_sw_m1), .h_bp_m1(h_bp_m1),
    .v_act_m1(v_act_m1), .v_fp_m1(v_fp_m1), .v_sw_m1(v_sw_m1), .v_bp_m1(v_bp_m1),
    .clk_div(clk_div), .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de),
    .gate_hsync(gate_hsync), .gate_vsync(gate_vsync), .ilace_req(ilace_req),
    .fid_first_req(fid_first_req), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .fid_o(fid_o), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .blank_err(blank_err)
  );

  typedef struct { int hs; int vs; int de; int fid; int px; int ln; int err; } exp_t;
  exp_t sbq[$];

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference model state
  int mh = 0, mv = 0, m_il = 0, m_fid = 0;
  int sha = 0, shf = 0, shs = 0, shb = 0, sva = 0, svf = 0, svs = 0, svb = 0;

  task automatic cmp(string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor and model: outputs after an edge reflect the state before it
  initial forever begin
    exp_t e;
    @(negedge clk);
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      cmp("hsync (R2)", int'(hsync_o), e.hs);
      cmp("vsync (R3)", int'(vsync_o), e.vs);
      cmp("de (R4)", int'(de_o), e.de);
      cmp("fid (R8)", int'(fid_o), e.fid);
      cmp("pix_cnt (R2)", int'(pix_cnt), e.px);
      cmp("line_cnt (R3)", int'(line_cnt), e.ln);
      cmp("blank_err (R11)", int'(blank_err), e.err);
    end
    if (rst) begin
      e = '{default: 0};
      mh = 0; mv = 0; m_il = 0; m_fid = 0;
      sha = 0; shf = 0; shs = 0; shb = 0; sva = 0; svf = 0; svs = 0; svb = 0;
    end else begin
      int la, lf, ls, htot, vla, vtot, hs_on, vs_on, bsum;
      la = sha + 1; lf = shf + 1; ls = shs + 1;
      htot = la + lf + ls + shb + 1;
      vla = m_il ? (sva + 1) / 2 : sva + 1;
      vtot = vla + svf + 1 + svs + 1 + svb + 1;
      hs_on = (mh >= la + lf) && (mh < la + lf + ls);
      vs_on = (mv >= vla + svf + 1) && (mv < vla + svf + 1 + svs + 1);
      e.hs = int'((out_en && hs_on && !gate_hsync) ^ inv_hsync);
      e.vs = int'((out_en && vs_on && !gate_vsync) ^ inv_vsync);
      e.de = int'((out_en && mh < la && mv < vla) ^ inv_de);
      e.fid = m_il & m_fid;
      e.px = mh; e.ln = mv;
      bsum = int'(h_fp_m1) + int'(h_sw_m1) + int'(h_bp_m1) + 3;
      e.err = (bsum * int'(clk_div) <= 8) ? 1 : 0;
      if (!out_en) begin
        mh = 0; mv = 0;
        sha = h_act_m1; shf = h_fp_m1; shs = h_sw_m1; shb = h_bp_m1;
        sva = v_act_m1; svf = v_fp_m1; svs = v_sw_m1; svb = v_bp_m1;
        m_il = int'(ilace_req); m_fid = int'(fid_first_req);
      end else if (pix_en) begin
        if (mh == htot - 1) begin
          mh = 0;
          if (mv == vtot - 1) begin
            mv = 0;
            sha = h_act_m1; shf = h_fp_m1; shs = h_sw_m1; shb = h_bp_m1;
            sva = v_act_m1; svf = v_fp_m1; svs = v_sw_m1; svb = v_bp_m1;
            if (m_il != 0) m_fid = 1 - m_fid;
          end else mv++;
        end else mh++;
      end
    end
    sbq.push_back(e);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; out_en = 0; pix_en = 1;
    h_act_m1 = 7; h_fp_m1 = 1; h_sw_m1 = 1; h_bp_m1 = 1;
    v_act_m1 = 3; v_fp_m1 = 0; v_sw_m1 = 0; v_bp_m1 = 0;
    clk_div = 1; inv_hsync = 0; inv_vsync = 0; inv_de = 0;
    gate_hsync = 0; gate_vsync = 0; ilace_req = 0; fid_first_req = 0;
    tag = "R1";
    step(3);
    rst = 0;
    inv_hsync = 1; inv_de = 1;            // idle levels follow inversion (R1)
    step(5);
    inv_hsync = 0; inv_de = 0;
    step(2);

    tag = "R2/R3/R4/R7";                  // progressive raster, 14 x 7 frame
    out_en = 1;
    step(200);

    tag = "R12";                          // pixel enable drops one cycle in three
    for (int i = 0; i < 150; i++) begin
      pix_en = (i % 3) != 0;
      step(1);
    end
    pix_en = 0;
    step(10);
    pix_en = 1;

    tag = "R5";
    inv_hsync = 1; inv_vsync = 1; inv_de = 1;
    step(100);
    inv_vsync = 0;                        // each bit on its own output
    step(50);
    inv_hsync = 0; inv_de = 0;

    tag = "R6";
    gate_hsync = 1;
    step(60);
    gate_hsync = 0; gate_vsync = 1; inv_vsync = 1;
    step(100);
    gate_vsync = 0; inv_vsync = 0;

    tag = "R10";                          // mid-frame change waits for frame end
    step(17);
    h_act_m1 = 5; h_bp_m1 = 2; v_act_m1 = 2;
    step(250);

    tag = "R8";                           // interlaced, 5 active lines -> 2 per field
    out_en = 0;
    ilace_req = 1; fid_first_req = 1; v_act_m1 = 4;
    step(3);
    out_en = 1;
    step(220);

    tag = "R9";                           // requests while enabled are ignored
    ilace_req = 0; fid_first_req = 0;
    step(160);
    out_en = 0;
    step(3);
    out_en = 1;
    tag = "R7";
    step(60);
    out_en = 0;

    tag = "R11";
    h_fp_m1 = 0; h_sw_m1 = 0; h_bp_m1 = 0; clk_div = 1;   // 3*1 -> flag
    step(4);
    clk_div = 3;                                          // 3*3 = 9 -> clear
    step(4);
    h_fp_m1 = 1; clk_div = 2;                             // 4*2 = 8 -> flag
    step(4);
    clk_div = 0;                                          // 0 -> flag
    step(4);
    h_bp_m1 = 5; clk_div = 1;                             // 9*1 -> clear
    step(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule